// File: doc/BRIEF.md
# GCR Telemetry Reply Decoder

This block turns the reply a motor controller sends on its telemetry line into a rotation rate figure. A capture unit records a free-running timer value at every edge of the reply waveform. Those timestamps reach this block as a stream: a start strobe carries the number of timestamps that follow, and then one timestamp is accepted on each cycle that `ts_valid` is high. The block measures the gap between each pair of neighbouring edges in bit times, at sixteen timer ticks per bit. From those run lengths it rebuilds a 21-bit line word.

The low 20 bits of the line word hold four 5-bit GCR symbols. Each symbol is mapped back to a nibble, which gives a 16-bit frame. The frame's four nibbles must XOR to all ones. The top twelve bits are a floating-point period, with a 3-bit exponent above a 9-bit mantissa. The period is expanded and divided into a fixed constant with rounding, on a sequential divider, to give the rate.

The result appears with a one-cycle `res_valid` pulse. A second start is only taken once that pulse has gone out. When any check fails, `res_error` pulses together with `res_valid`.

Top module: `gcr_telem_decoder`

## Requirements
- R1: After reset, `res_valid` and `res_error` are low and `res_value` is zero.
- R2: The run length of an edge gap is (delta + 8) / 16 in integer arithmetic. Delta is the difference between consecutive timestamps, taken modulo 2^32 so that a timer wrap is harmless.
- R3: Each run of length L shifts the line word left by L and sets bit L-1. After the last timestamp, a closing run of 21 minus the bits gathered so far is appended. The number of timestamps is the number of edges, so the first timestamp starts the first run.
- R4: Once 21 bits have been gathered, the remaining timestamps of the frame are consumed but do not change the result.
- R5: The frame is a framing error, with `res_value` = 0xFFFF, when a run would take the total past 21 bits, when any run rounds to zero length, or when the count is zero.
- R6: Symbol k (bits 5k+4..5k of the line word) gives nibble k of the frame. The symbol map is: 0x19→0, 0x1B→1, 0x12→2, 0x13→3, 0x1D→4, 0x15→5, 0x16→6, 0x17→7, 0x1A→8, 0x09→9, 0x0A→10, 0x0B→11, 0x1E→12, 0x0D→13, 0x0E→14, 0x0F→15. Every other symbol gives 0.
- R7: With frame F, let X = F ^ (F >> 8), then Y = X ^ (X >> 4). The low nibble of Y must be 0xF, or the result is an error.
- R8: If the payload F[15:4] equals 0xFFF, the result is 0 without error.
- R9: For any other payload, the period is F[12:4] (mantissa) shifted left by F[15:13] (exponent). A zero period is an error.
- R10: The result is (600000 + period/2) / period, truncated. It is computed by a bit-serial divider, and `res_valid` stays low for at least 20 cycles after the last timestamp while the divider runs.
- R11: `res_valid` is a single-cycle pulse. `res_error` is only ever high together with `res_valid`, and then `res_value` is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when the block is idle |
| frame_count | input | 6 | Number of timestamps in the frame, sampled with `start` |
| ts_valid | input | 1 | A timestamp is present on `ts_data` |
| ts_data | input | 32 | Captured edge time in timer ticks |
| res_valid | output | 1 | One-cycle pulse when a result is ready |
| res_error | output | 1 | Pulses with `res_valid` when the frame failed a check |
| res_value | output | 20 | Rate result, 0 when stopped, 0xFFFF on error |

## Verification
The bench builds frames from payloads with its own GCR encoder and timestamp generator. It adds gap jitter from -8 to +7 ticks, which rounds to the same run length. A design that rounded the wrong way would decode a different word and fail the checksum. A start value near the top of the timer range forces a wrap, so a design that used signed or unwrapped gaps would produce runs of absurd length.

Corner cases are then covered directly:
- a zero count, a single timestamp, a duplicated edge, and a run that overshoots 21 bits must all give an error, where a careless decoder would emit a number;
- trailing timestamps after a complete word must be ignored, where a design that kept shifting would corrupt the symbols;
- the stop payload must give 0, where a design without this check would divide;
- a zero mantissa must give an error, where a design without this check would divide by zero.

Every nibble value is swept once through the symbol map. The wait before a divided result is measured to confirm that the divider really iterates.

// File: rtl/gcr_telem_pkg.sv
package gcr_telem_pkg;

  localparam int LINE_BITS = 21;
  localparam int SYM_W     = 5;
  localparam int NIB_W     = 4;
  localparam int NUM_SYMS  = 4;
  localparam int FRAME_W   = NUM_SYMS * NIB_W;
  localparam int TICK_SH   = 4;                  // 16 ticks per bit
  localparam int MANT_W    = 9;
  localparam int EXP_W     = 3;
  localparam int PER_W     = MANT_W + (1 << EXP_W) - 1;
  localparam int RUN_W     = 33 - TICK_SH;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_FILL, ST_DECODE, ST_DIV, ST_DONE
  } ctl_state_t;

  // gap in ticks -> rounded length in bit times
  function automatic logic [RUN_W-1:0] run_len(input logic [31:0] delta);
    logic [32:0] s;
    s = {1'b0, delta} + 33'd8;
    return s[32:TICK_SH];
  endfunction

  // shift a run of len bits (len >= 1) into the line word
  function automatic logic [LINE_BITS-1:0] append_run(
      input logic [LINE_BITS-1:0] w, input logic [4:0] len);
    return (w << len) | (LINE_BITS'(1) << (len - 5'd1));
  endfunction

  function automatic logic [NIB_W-1:0] gcr_nibble(input logic [SYM_W-1:0] sym);
    logic [NIB_W-1:0] n;
    case (sym)
      5'h19: n = 4'h0;
      5'h1B: n = 4'h1;
      5'h12: n = 4'h2;
      5'h13: n = 4'h3;
      5'h1D: n = 4'h4;
      5'h15: n = 4'h5;
      5'h16: n = 4'h6;
      5'h17: n = 4'h7;
      5'h1A: n = 4'h8;
      5'h09: n = 4'h9;
      5'h0A: n = 4'hA;
      5'h0B: n = 4'hB;
      5'h1E: n = 4'hC;
      5'h0D: n = 4'hD;
      5'h0E: n = 4'hE;
      5'h0F: n = 4'hF;
      default: n = 4'h0;
    endcase
    return n;
  endfunction

  function automatic logic frame_sum_ok(input logic [FRAME_W-1:0] f);
    logic [FRAME_W-1:0] x;
    logic [FRAME_W-1:0] y;
    x = f ^ (f >> 8);
    y = x ^ (x >> 4);
    return y[3:0] == 4'hF;
  endfunction

  function automatic logic [PER_W-1:0] expand_period(
      input logic [MANT_W+EXP_W-1:0] pl);
    return PER_W'(pl[MANT_W-1:0]) << pl[MANT_W+EXP_W-1:MANT_W];
  endfunction

endpackage

// File: rtl/gcr_run_accum.sv
module gcr_run_accum
  import gcr_telem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic [31:0]          ts,
  input  logic                 fill,
  output logic [LINE_BITS-1:0] word,
  output logic                 frame_bad
);

  logic [31:0]          prev_q;
  logic                 seen_q;
  logic [4:0]           bits_q;
  logic                 over_q;
  logic                 zero_q;
  logic [LINE_BITS-1:0] word_q;

  logic [RUN_W-1:0] len_w;
  logic [4:0]       room_w;
  logic             open_w;

  assign len_w  = run_len(ts - prev_q);
  assign room_w = 5'(LINE_BITS) - bits_q;
  assign open_w = bits_q < 5'(LINE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      bits_q <= '0;
      over_q <= 1'b0;
      zero_q <= 1'b0;
      word_q <= '0;
    end else if (clr) begin
      seen_q <= 1'b0;
      bits_q <= '0;
      over_q <= 1'b0;
      zero_q <= 1'b0;
      word_q <= '0;
    end else if (push) begin
      prev_q <= ts;
      seen_q <= 1'b1;
      if (seen_q && open_w) begin
        if (len_w == '0) begin
          zero_q <= 1'b1;
        end else if (len_w > RUN_W'(room_w)) begin
          over_q <= 1'b1;
          bits_q <= 5'(LINE_BITS);
        end else begin
          bits_q <= bits_q + len_w[4:0];
          word_q <= append_run(word_q, len_w[4:0]);
        end
      end
    end else if (fill && seen_q && open_w) begin
      word_q <= append_run(word_q, room_w);
      bits_q <= 5'(LINE_BITS);
    end
  end

  assign word      = word_q;
  assign frame_bad = over_q | zero_q | ~seen_q;

  // R4
  bits_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= 5'(LINE_BITS));

  // R3
  fill_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !clr && !push && seen_q) |=> (bits_q == 5'(LINE_BITS)));

endmodule

// File: rtl/gcr_frame_decode.sv
module gcr_frame_decode
  import gcr_telem_pkg::*;
(
  input  logic [NUM_SYMS*SYM_W-1:0] syms,
  output logic                      sum_ok,
  output logic                      stopped,
  output logic                      per_zero,
  output logic [PER_W-1:0]          period
);

  logic [FRAME_W-1:0]       frame_w;
  logic [FRAME_W-NIB_W-1:0] payload_w;

  for (genvar k = 0; k < NUM_SYMS; k++) begin : g_sym
    assign frame_w[k*NIB_W +: NIB_W] = gcr_nibble(syms[k*SYM_W +: SYM_W]);
  end

  assign payload_w = frame_w[FRAME_W-1:NIB_W];
  assign sum_ok    = frame_sum_ok(frame_w);
  assign stopped   = &payload_w;
  assign period    = expand_period(payload_w);
  assign per_zero  = payload_w[MANT_W-1:0] == '0;

endmodule

// File: rtl/gcr_rate_div.sv
module gcr_rate_div #(
  parameter int DVD_W = 20,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q;
  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  logic [DVS_W:0]   rem_sh;
  logic             fits;
  logic [DVS_W-1:0] rem_nx;

  assign rem_sh = {rem_q, quo_q[DVD_W-1]};
  assign fits   = rem_sh >= {1'b0, dvs_q};
  assign rem_nx = fits ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (cnt_q == CNT_W'(1));
      if (go && !busy_q) begin
        quo_q  <= dividend;
        dvd_q  <= dividend;
        dvs_q  <= divisor;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[DVD_W-2:0], fits};
        rem_q <= rem_nx;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R10
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((64'(quo_q) * 64'(dvs_q) + 64'(rem_q) == 64'(dvd_q)) && (rem_q < dvs_q)));

  // R10
  div_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);

endmodule

// File: rtl/gcr_telem_decoder.sv
module gcr_telem_decoder
  import gcr_telem_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DVD_W    = 20,
  parameter int RATE_NUM = 600000,
  parameter int ERR_CODE = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_count,
  input  logic             ts_valid,
  input  logic [31:0]      ts_data,
  output logic             res_valid,
  output logic             res_error,
  output logic [DVD_W-1:0] res_value
);

  ctl_state_t       state_q;
  logic [CNT_W-1:0] left_q;
  logic             err_q;
  logic [DVD_W-1:0] value_q;

  logic                 acc_clr;
  logic                 acc_push;
  logic                 acc_fill;
  logic [LINE_BITS-1:0] line_word;
  logic                 frame_bad;

  logic             sum_ok;
  logic             stopped;
  logic             per_zero;
  logic [PER_W-1:0] period;

  logic             decode_fail;
  logic             div_go;
  logic             div_busy;
  logic             div_done;
  logic [DVD_W-1:0] div_quot;
  logic [DVD_W-1:0] dividend;

  assign acc_clr  = (state_q == ST_IDLE) && start;
  assign acc_push = (state_q == ST_COLLECT) && ts_valid;
  assign acc_fill = (state_q == ST_FILL);

  gcr_run_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (acc_clr),
    .push      (acc_push),
    .ts        (ts_data),
    .fill      (acc_fill),
    .word      (line_word),
    .frame_bad (frame_bad)
  );

  gcr_frame_decode u_decode (
    .syms     (line_word[NUM_SYMS*SYM_W-1:0]),
    .sum_ok   (sum_ok),
    .stopped  (stopped),
    .per_zero (per_zero),
    .period   (period)
  );

  assign decode_fail = frame_bad || !sum_ok || (!stopped && per_zero);
  assign div_go      = (state_q == ST_DECODE) && !decode_fail && !stopped;
  assign dividend    = DVD_W'(RATE_NUM) + DVD_W'(period >> 1);

  gcr_rate_div #(.DVD_W(DVD_W), .DVS_W(PER_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (dividend),
    .divisor  (period),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      err_q   <= 1'b0;
      value_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            left_q  <= frame_count;
            err_q   <= 1'b0;
            state_q <= (frame_count == '0) ? ST_FILL : ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (ts_valid) begin
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) state_q <= ST_FILL;
          end
        end
        ST_FILL: state_q <= ST_DECODE;
        ST_DECODE: begin
          if (decode_fail) begin
            err_q   <= 1'b1;
            value_q <= DVD_W'(ERR_CODE);
            state_q <= ST_DONE;
          end else if (stopped) begin
            value_q <= '0;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            value_q <= div_quot;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = (state_q == ST_DONE);
  assign res_error = (state_q == ST_DONE) && err_q;
  assign res_value = value_q;

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R11
  err_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_error |-> (res_valid && res_value == DVD_W'(ERR_CODE)));

  // R10
  quot_from_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error && res_value != '0) |-> $past(div_done));

  // R10
  div_idle_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == ST_DIV));

endmodule

// File: tb/test_gcr_telem_decoder.sv
`timescale 1ns/1ps
module test_gcr_telem_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  frame_count = '0;
  logic        ts_valid = 1'b0;
  logic [31:0] ts_data = '0;
  logic        res_valid;
  logic        res_error;
  logic [19:0] res_value;

  always #2 clk = ~clk;

  gcr_telem_decoder i_gcr_telem_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
    .ts_valid(ts_valid), .ts_data(ts_data),
    .res_valid(res_valid), .res_error(res_error), .res_value(res_value)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] tsb [0:27];
  int nts;
  logic        got_e;
  logic [19:0] got_v;
  int          lat;

  // {payload[11:0], checksum flip[3:0], jitter[7:0] signed, base[31:0]}
  localparam logic [55:0] VEC [10] = '{
    {12'h001, 4'h0, 8'sd0,  32'h0000_0000},
    {12'hFFF, 4'h0, 8'sd0,  32'h0000_0100},
    {12'h000, 4'h0, 8'sd0,  32'h0000_0000},
    {12'h1FF, 4'h0, 8'sd7,  32'h0000_1000},
    {12'hE01, 4'h0, -8'sd8, 32'h0012_3456},
    {12'h3A7, 4'h0, 8'sd3,  32'hFFFF_FF00},
    {12'hFFE, 4'h0, 8'sd0,  32'h0000_0040},
    {12'h123, 4'h5, 8'sd0,  32'h0000_0000},
    {12'h200, 4'h0, 8'sd0,  32'h0000_0000},
    {12'h5C3, 4'h0, -8'sd5, 32'h0000_0007}
  };

  task automatic check(input string req, input bit ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'h19;  4'h1: return 5'h1B;  4'h2: return 5'h12;  4'h3: return 5'h13;
      4'h4: return 5'h1D;  4'h5: return 5'h15;  4'h6: return 5'h16;  4'h7: return 5'h17;
      4'h8: return 5'h1A;  4'h9: return 5'h09;  4'hA: return 5'h0A;  4'hB: return 5'h0B;
      4'hC: return 5'h1E;  4'hD: return 5'h0D;  4'hE: return 5'h0E;  default: return 5'h0F;
    endcase
  endfunction

  function automatic logic [20:0] mk_word(input logic [11:0] pl, input logic [3:0] flip);
    logic [3:0] ck;
    ck = ~(pl[11:8] ^ pl[7:4] ^ pl[3:0]) ^ flip;
    return {1'b1, enc(pl[11:8]), enc(pl[7:4]), enc(pl[3:0]), enc(ck)};
  endfunction

  // mode 0: edges only; 1: closing edge plus trailing junk; 2: closing run too long
  task automatic build(input logic [20:0] w, input int jit, input logic [31:0] base, input int mode);
    logic [31:0] t;
    int last;
    t = base; tsb[0] = t; nts = 1; last = 20;
    for (int b = 19; b >= 0; b--) begin
      if (w[b]) begin
        t = t + 32'(16 * (last - b) + jit);
        tsb[nts] = t; nts++; last = b;
      end
    end
    if (mode == 1) begin
      t = t + 32'(16 * (last + 1));
      tsb[nts] = t; nts++;
      tsb[nts] = t + 32'd3; nts++;
      tsb[nts] = t + 32'd4000; nts++;
    end else if (mode == 2) begin
      t = t + 32'(16 * (last + 2));
      tsb[nts] = t; nts++;
    end
  endtask

  task automatic expect_for(input logic [11:0] pl, input logic [3:0] flip,
                            output bit e, output logic [19:0] v);
    int p;
    p = int'(pl[8:0]) << pl[11:9];
    if (flip != 0) begin e = 1; v = 20'hFFFF; end
    else if (pl == 12'hFFF) begin e = 0; v = 0; end
    else if (p == 0) begin e = 1; v = 20'hFFFF; end
    else begin e = 0; v = 20'((600000 + p / 2) / p); end
  endtask

  task automatic run(input int cnt);
    @(negedge clk);
    start = 1'b1; frame_count = 6'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      ts_valid = 1'b1; ts_data = tsb[i];
      @(negedge clk);
    end
    ts_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 300) begin
      @(negedge clk); lat++;
    end
    got_e = res_error; got_v = res_value;
    check("R11 timeout", res_valid, 0, 1);
    @(negedge clk);
    check("R11 pulse", !res_valid && !res_error, res_valid, 0);
  endtask

  task automatic frame_test(input string req, input logic [11:0] pl, input logic [3:0] flip,
                            input int jit, input logic [31:0] base, input int mode);
    bit e; logic [19:0] v;
    build(mk_word(pl, flip), jit, base, mode);
    expect_for(pl, flip, e, v);
    if (mode == 2) begin e = 1; v = 20'hFFFF; end
    run(nts);
    check({req, " error"}, got_e == e, got_e, e);
    check({req, " value"}, got_v == v, got_v, v);
    if (!e && v != 0) check("R10 latency", lat >= 20, lat, 20);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", res_valid == 0, res_valid, 0);
    check("R1 error", res_error == 0, res_error, 0);
    check("R1 value", res_value == 0, res_value, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", res_valid == 0 && res_value == 0, res_value, 0);

    // R2 R3 R7 R8 R9 R10 table walk
    for (int k = 0; k < 10; k++) begin
      frame_test("R2 R3 R9 R10 table", VEC[k][55:44], VEC[k][43:40],
                 int'($signed(VEC[k][39:32])), VEC[k][31:0], 0);
    end

    // R6 every nibble through the symbol map
    for (int n = 0; n < 16; n++) begin
      frame_test("R6 nibble", {4'(n), ~4'(n), 4'h7}, 4'h0, 0, 32'(n * 977), 0);
    end

    // R8 stop payload with jitter
    frame_test("R8 stop", 12'hFFF, 4'h0, 5, 32'h55, 0);

    // R7 bad checksum
    frame_test("R7 checksum", 12'h0F3, 4'h8, 0, 32'h0, 0);

    // R4 trailing timestamps ignored
    frame_test("R4 trailing", 12'h1FF, 4'h0, 2, 32'h9000, 1);

    // R5 run overshoot
    frame_test("R5 overshoot", 12'h3A7, 4'h0, 0, 32'h0, 2);

    // R5 zero count
    run(0);
    check("R5 count zero error", got_e == 1, got_e, 1);
    check("R5 count zero value", got_v == 20'hFFFF, got_v, 20'hFFFF);

    // R5 duplicated edge gives zero-length run
    build(mk_word(12'h3A7, 4'h0), 0, 32'h100, 0);
    for (int i = nts; i >= 2; i--) tsb[i] = tsb[i-1];
    nts++;
    run(nts);
    check("R5 zero run error", got_e == 1, got_e, 1);
    check("R5 zero run value", got_v == 20'hFFFF, got_v, 20'hFFFF);

    // R3 single timestamp: all-zero symbols fail the sum (R7)
    tsb[0] = 32'h77;
    run(1);
    check("R3 single edge error", got_e == 1, got_e, 1);

    // recovery after errors
    frame_test("R10 recovery", 12'h001, 4'h0, 0, 32'h0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule